// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Controller

This block is a general-purpose I/O peripheral that sits on a simple synchronous register bus. It has one pin per register bit, so the register width is also the pin count. Software drives the pads through an output latch and a direction register, and reads the live pin levels back through a data register.

The latch can be changed in three ways. A write to the data register loads the whole latch. A write to the set register raises only the bits written as 1. A write to the clear register lowers only the bits written as 1. Because of the set and clear registers, software can change single pins without a read-modify-write sequence.

Two build-time parameters change how the block behaves. The first picks the meaning of a 1 in the direction register: it makes the pin either an output or an input. The second can reverse the order of the pins, so that pin n uses register bit WIDTH-1-n.

Top module: `mmio_gpio_ctrl`

## Requirements
- R1: While reset is high, and on the first edge after it, pin_out is all zeros and pin_oe is all zeros. A read of the direction register then returns all zeros in output polarity (DIR_IS_INPUT=0) or all ones in input polarity (DIR_IS_INPUT=1).
- R2: A write to address 1 (set) raises every latch bit whose written bit is 1 and leaves every other bit unchanged. The change is visible on pin_out after the edge of that write.
- R3: A write to address 2 (clear) lowers every latch bit whose written bit is 1 and leaves every other bit unchanged. The change is visible after the edge of that write.
- R4: A write to address 0 (data) loads the whole latch with the written word. Exactly one register is written per bus write.
- R5: A read of address 0 returns the pin levels. A pin change made before clock edge A shows up in bus_rdata for a read whose address is sampled at edge A+2, and not for a read sampled at edge A or A+1.
- R6: A read of address 1 or address 2 returns the current output latch, in register bit order.
- R7: With DIR_IS_INPUT=0, a direction bit of 1 makes the pin an output (pin_oe=1), and a direction bit of 0 makes it an input.
- R8: With DIR_IS_INPUT=1, a direction bit of 1 makes the pin an input (pin_oe=0), and a direction bit of 0 makes it an output.
- R9: With BIT_REVERSE=1, pin n uses register bit WIDTH-1-n for the latch, the direction register and the data read. With BIT_REVERSE=0, pin n uses bit n.
- R10: bus_rdata is registered with one cycle of latency. It updates on each edge where bus_we is low, and it holds its value on an edge where bus_we is high.
- R11: A write to address 3 (direction) loads the direction register, and a read of address 3 returns it.
- R12: WIDTH must be 8, 16, 32 or 64. Any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 data, 1 set, 2 clear, 3 direction |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Registered read data |
| pin_in | input | WIDTH | Pad input levels (asynchronous) |
| pin_out | output | WIDTH | Per-pin output value |
| pin_oe | output | WIDTH | Per-pin output enable |

## Verification
The assertions check on every cycle:
- the set, clear and load rules of the latch, bit by bit, against the word that was written;
- that only one register is written per bus write;
- that the direction register loads;
- that the outputs are idle after reset;
- that the read register holds during a write.

Only the bench's scenarios can show the rest: the two-clock synchronizer lag on data reads, the mapping to pins under both direction polarities, and the reversed bit order. The bench covers these by running a second instance with 16 bits, input polarity and reversed bit order beside the default instance.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA = 2'd0,
    REG_SET  = 2'd1,
    REG_CLR  = 2'd2,
    REG_DIR  = 2'd3
  } gpio_reg_e;

  function automatic bit legal_width(int unsigned w);
    return (w == 8) || (w == 16) || (w == 32) || (w == 64);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_bit_map.sv
module gpio_bit_map #(
  parameter int unsigned WIDTH   = 32,
  parameter bit          REVERSE = 1'b0
) (
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (REVERSE) begin : g_rev
      assign dout[i] = din[WIDTH-1-i];
    end else begin : g_fwd
      assign dout[i] = din[i];
    end
  end
endmodule

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
  import gpio_pkg::*;
(
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  output logic              wr_data,
  output logic              wr_set,
  output logic              wr_clr,
  output logic              wr_dir
);
  always_comb begin
    wr_data = 1'b0;
    wr_set  = 1'b0;
    wr_clr  = 1'b0;
    wr_dir  = 1'b0;
    if (bus_we) begin
      unique case (gpio_reg_e'(bus_addr))
        REG_DATA: wr_data = 1'b1;
        REG_SET:  wr_set  = 1'b1;
        REG_CLR:  wr_clr  = 1'b1;
        REG_DIR:  wr_dir  = 1'b1;
        default:  wr_data = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_data,
  input  logic             wr_set,
  input  logic             wr_clr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] lat_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q <= '0;
    end else if (wr_data) begin
      lat_q <= wdata;
    end else if (wr_set) begin
      lat_q <= lat_q | wdata;
    end else if (wr_clr) begin
      lat_q <= lat_q & ~wdata;
    end
  end

  // R2: bits written as 1 go high, the rest keep their value
  a_r2_set_ones: assert property (@(posedge clk) disable iff (rst)
    wr_set |=> ((lat_q & $past(wdata)) == $past(wdata)));
  a_r2_set_keep: assert property (@(posedge clk) disable iff (rst)
    wr_set |=> ((lat_q & ~$past(wdata)) == ($past(lat_q) & ~$past(wdata))));

  // R3: bits written as 1 go low, the rest keep their value
  a_r3_clr_zeros: assert property (@(posedge clk) disable iff (rst)
    wr_clr |=> ((lat_q & $past(wdata)) == '0));
  a_r3_clr_keep: assert property (@(posedge clk) disable iff (rst)
    wr_clr |=> ((lat_q & ~$past(wdata)) == ($past(lat_q) & ~$past(wdata))));

  // R4: a data write loads the whole word
  a_r4_load: assert property (@(posedge clk) disable iff (rst)
    wr_data |=> (lat_q == $past(wdata)));
endmodule

// File: rtl/mmio_gpio_ctrl.sv
module mmio_gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH        = 32,
  parameter bit          DIR_IS_INPUT = 1'b0,
  parameter bit          BIT_REVERSE  = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe
);
  localparam logic [WIDTH-1:0] DIR_RESET = DIR_IS_INPUT ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

  // R12: only the four legal register widths elaborate
  if (!legal_width(WIDTH)) begin : g_bad_width
    $error("mmio_gpio_ctrl: WIDTH must be 8, 16, 32 or 64");
  end

  logic             wr_data, wr_set, wr_clr, wr_dir;
  logic [WIDTH-1:0] lat_q;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] oe_reg;
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] data_reg;

  gpio_reg_decode u_dec (
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .wr_data  (wr_data),
    .wr_set   (wr_set),
    .wr_clr   (wr_clr),
    .wr_dir   (wr_dir)
  );

  gpio_out_latch #(.WIDTH(WIDTH)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .wr_data (wr_data),
    .wr_set  (wr_set),
    .wr_clr  (wr_clr),
    .wdata   (bus_wdata),
    .lat_q   (lat_q)
  );

  // R11: direction register
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= DIR_RESET;
    end else if (wr_dir) begin
      dir_q <= bus_wdata;
    end
  end

  // R7 / R8: direction polarity
  if (DIR_IS_INPUT) begin : g_dir_in
    assign oe_reg = ~dir_q;
  end else begin : g_dir_out
    assign oe_reg = dir_q;
  end

  gpio_sync #(.WIDTH(WIDTH)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pin_in),
    .sync_out (pin_sync)
  );

  // R9: register bit order to pin order, and back
  gpio_bit_map #(.WIDTH(WIDTH), .REVERSE(BIT_REVERSE)) u_map_out (
    .din (lat_q), .dout (pin_out)
  );
  gpio_bit_map #(.WIDTH(WIDTH), .REVERSE(BIT_REVERSE)) u_map_oe (
    .din (oe_reg), .dout (pin_oe)
  );
  gpio_bit_map #(.WIDTH(WIDTH), .REVERSE(BIT_REVERSE)) u_map_in (
    .din (pin_sync), .dout (data_reg)
  );

  // R5 / R6 / R10: registered read port, held during writes
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (!bus_we) begin
      unique case (gpio_reg_e'(bus_addr))
        REG_DATA: bus_rdata <= data_reg;
        REG_SET:  bus_rdata <= lat_q;
        REG_CLR:  bus_rdata <= lat_q;
        REG_DIR:  bus_rdata <= dir_q;
        default:  bus_rdata <= '0;
      endcase
    end
  end

  // R1: pads idle after reset
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> ((pin_out == '0) && (pin_oe == '0)));

  // R4: one register per write
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_data, wr_set, wr_clr, wr_dir}) && (bus_we == (wr_data | wr_set | wr_clr | wr_dir)));

  // R11: direction load
  a_r11_dir_load: assert property (@(posedge clk) disable iff (rst)
    wr_dir |=> (dir_q == $past(bus_wdata)));

  // R10: read data held while writing
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    bus_we |=> $stable(bus_rdata));
endmodule

// File: tb/mmio_gpio_ctrl_bench.sv
`timescale 1ns/1ps
module mmio_gpio_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_addr = 2'd0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata_a;
  logic [15:0] rdata_b;
  logic [31:0] pins_a = '0;
  logic [15:0] pins_b = '0;
  logic [31:0] out_a, oe_a;
  logic [15:0] out_b, oe_b;

  // model state (register bit order)
  logic [31:0] m_lat_a, m_dir_a;
  logic [15:0] m_lat_b, m_dir_b;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  // default instance: 32 bits, 1 means output, natural order
  mmio_gpio_ctrl u_mmio_gpio_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_a),
    .pin_in(pins_a), .pin_out(out_a), .pin_oe(oe_a)
  );

  // second instance: 16 bits, 1 means input, reversed order
  mmio_gpio_ctrl #(.WIDTH(16), .DIR_IS_INPUT(1'b1), .BIT_REVERSE(1'b1)) u_mmio_gpio_ctrl_alt (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata[15:0]), .bus_rdata(rdata_b),
    .pin_in(pins_b), .pin_out(out_b), .pin_oe(oe_b)
  );

  function automatic logic [15:0] rev16(logic [15:0] v);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = v[15-i];
    return r;
  endfunction

  function automatic logic [31:0] model_write(logic [31:0] cur, logic [1:0] a, logic [31:0] d);
    case (a)
      2'd0:    return d;
      2'd1:    return cur | d;
      2'd2:    return cur & ~d;
      default: return cur;
    endcase
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    m_lat_a = model_write(m_lat_a, a, d);
    m_lat_b = 16'(model_write({16'h0, m_lat_b}, a, d));
    if (a == 2'd3) begin
      m_dir_a = d;
      m_dir_b = d[15:0];
    end
  endtask

  task automatic do_read(logic [1:0] a);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk_pads(string req);
    chk({req, " out_a"}, 64'(out_a), 64'(m_lat_a));
    chk({req, " oe_a"},  64'(oe_a),  64'(m_dir_a));
    chk({req, " out_b"}, 64'(out_b), 64'(rev16(m_lat_b)));
    chk({req, " oe_b"},  64'(oe_b),  64'(rev16(~m_dir_b)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] held_a;
    logic [15:0] held_b;
    logic [31:0] old_pins_a;
    logic [15:0] old_pins_b;
    void'($urandom(32'd1234));
    m_lat_a = '0; m_dir_a = '0; m_lat_b = '0; m_dir_b = 16'hFFFF;
    repeat (3) @(negedge clk);
    // R1: pads idle during reset
    chk("R1 out_a in reset", 64'(out_a), 64'h0);
    chk("R1 oe_b in reset",  64'(oe_b),  64'h0);
    rst = 1'b0;
    @(negedge clk);
    chk_pads("R1");
    do_read(2'd3);
    chk("R1 dir_a reset", 64'(rdata_a), 64'h0);
    chk("R1 dir_b reset", 64'(rdata_b), 64'hFFFF);

    // R4 load, R6 readback through set and clear addresses
    do_write(2'd0, 32'hA5C3_0F81);
    chk_pads("R4");
    do_read(2'd1);
    chk("R6 set-addr read a", 64'(rdata_a), 64'(m_lat_a));
    chk("R6 set-addr read b", 64'(rdata_b), 64'(m_lat_b));
    do_read(2'd2);
    chk("R6 clr-addr read a", 64'(rdata_a), 64'(m_lat_a));

    // R10: read register holds across a write
    held_a = rdata_a; held_b = rdata_b;
    do_write(2'd1, 32'h0000_00F0);
    chk("R10 hold a", 64'(rdata_a), 64'(held_a));
    chk("R10 hold b", 64'(rdata_b), 64'(held_b));
    chk_pads("R2");

    // R2/R3 corner cases: zero word, all ones
    do_write(2'd1, 32'h0);
    chk_pads("R2 zero set");
    do_write(2'd2, 32'h0);
    chk_pads("R3 zero clr");
    do_write(2'd2, 32'hFFFF_FFFF);
    chk_pads("R3 all clr");
    chk("R3 out_a zero", 64'(out_a), 64'h0);
    do_write(2'd1, 32'h8000_0001);
    chk_pads("R2 edge bits");
    chk("R9 alt pin15 from bit0", 64'(out_b), 64'h8000);

    // R7/R8/R9/R11 direction
    do_write(2'd3, 32'h0000_00FF);
    chk_pads("R11");
    chk("R7 oe_a", 64'(oe_a), 64'h0000_00FF);
    chk("R8 R9 oe_b", 64'(oe_b), 64'h00FF);
    do_read(2'd3);
    chk("R11 dir read a", 64'(rdata_a), 64'h0000_00FF);
    chk("R11 dir read b", 64'(rdata_b), 64'h00FF);

    // R5: synchronizer lag, reads sampled at edges A, A+1, A+2
    pins_a = 32'h1234_5678; pins_b = 16'h0001;
    repeat (4) @(negedge clk);
    do_read(2'd0);
    chk("R5 settle a", 64'(rdata_a), 64'h1234_5678);
    chk("R5 R9 settle b", 64'(rdata_b), 64'h8000);
    old_pins_a = pins_a; old_pins_b = pins_b;
    pins_a = 32'hCAFE_F00D; pins_b = 16'h00F1;
    @(posedge clk); @(negedge clk);
    chk("R5 lag edge A", 64'(rdata_a), 64'(old_pins_a));
    @(negedge clk);
    chk("R5 lag edge A+1", 64'(rdata_a), 64'(old_pins_a));
    chk("R5 lag edge A+1 b", 64'(rdata_b), 64'(rev16(old_pins_b)));
    @(negedge clk);
    chk("R5 new at A+2", 64'(rdata_a), 64'hCAFE_F00D);
    chk("R5 R9 new at A+2 b", 64'(rdata_b), 64'(rev16(16'h00F1)));

    // random stimulus over all registers
    for (int it = 0; it < 300; it++) begin
      logic [1:0]  a;
      logic [31:0] d;
      a = 2'($urandom_range(0, 3));
      d = $urandom();
      do_write(a, d);
      chk_pads("R2 R3 R4 R7 R8 random");
      if ((it % 5) == 0) begin
        a = 2'($urandom_range(0, 3));
        do_read(a);
        case (a)
          2'd0: begin
            chk("R5 random a", 64'(rdata_a), 64'(pins_a));
            chk("R5 random b", 64'(rdata_b), 64'(rev16(pins_b)));
          end
          2'd3: begin
            chk("R11 random a", 64'(rdata_a), 64'(m_dir_a));
            chk("R11 random b", 64'(rdata_b), 64'(m_dir_b));
          end
          default: begin
            chk("R6 random a", 64'(rdata_a), 64'(m_lat_a));
            chk("R6 random b", 64'(rdata_b), 64'(m_lat_b));
          end
        endcase
      end
    end

    // R1: reset again returns pads to idle
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    m_lat_a = '0; m_dir_a = '0; m_lat_b = '0; m_dir_b = 16'hFFFF;
    chk_pads("R1 re-reset");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule